// File: doc/BRIEF.md
# Gain-Adjust Flag Generator

This block watches a stream of converter sample magnitudes, one per clock, and raises two flags for an external gain-control loop. The reduce flag goes high on any sample whose coarse level is above a programmable ceiling. The raise flag goes high only after the magnitude has stayed below a programmable fine floor for a programmable number of consecutive samples.

Each incoming sample is registered once before it is compared, so both flags answer the sample of the previous clock. The flags follow the level of each sample, not an envelope. Each flag is stretched so that, once set, it stays high for at least two clocks. The thresholds and the dwell length are static settings held by the surrounding logic.

Top module: `gain_flag_gen`

## Requirements
- R1: While `rst_n` is low, both flags are low and the consecutive-sample count is cleared.
- R2: `dec_gain_o` is set when the top `COARSE_W` bits of a sample are strictly greater than `coarse_hi_i`. A sample whose top bits equal the ceiling does not set it.
- R3: Each flag answers the sample presented at the previous rising edge. After a stretch has expired, `dec_gain_o` falls on the clock after the first sample at or below the ceiling.
- R4: `inc_gain_o` is set on the clock after the Nth consecutive sample strictly below `fine_lo_i`, where N is the effective dwell setting. A run shorter than N does not set it.
- R5: A sample equal to or above `fine_lo_i` restarts the consecutive count from zero.
- R6: After the dwell has been met, `inc_gain_o` stays high while samples remain below the floor. Once any stretch has expired, it falls on the clock after the first sample at or above the floor.
- R7: A dwell setting of 0 behaves as a dwell of 1.
- R8: Once either flag rises, it stays high for at least `HOLD_MIN` (2) clocks, even if its condition lasted only one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mag_i | input | MAG_W (13) | Sample magnitude, one per clock |
| coarse_hi_i | input | COARSE_W (3) | Ceiling compared with the top bits of the magnitude |
| fine_lo_i | input | MAG_W (13) | Floor compared with the full magnitude |
| dwell_i | input | DWELL_W (16) | Number of consecutive below-floor samples required, 0 read as 1 |
| dec_gain_o | output | 1 | Reduce-gain flag |
| inc_gain_o | output | 1 | Raise-gain flag |

## Verification
The bench builds the block with its default parameters: a 13-bit magnitude, a 3-bit ceiling, a 16-bit dwell setting and a two-clock minimum hold. With these values the samples 6143 and 6144 sit on either side of the ceiling of 5. The floor is set to 1000 so that a sample equal to it exercises the restart. Small dwell values (0, 1, 5) keep the runs short, so runs one sample short of the dwell, single-sample spikes and interrupted runs can all be driven within a few hundred clocks.

// File: rtl/gain_flag_gen.sv
module gain_flag_gen #(
  parameter int MAG_W    = 13,
  parameter int COARSE_W = 3,
  parameter int DWELL_W  = 16,
  parameter int HOLD_MIN = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAG_W-1:0]    mag_i,
  input  logic [COARSE_W-1:0] coarse_hi_i,
  input  logic [MAG_W-1:0]    fine_lo_i,
  input  logic [DWELL_W-1:0]  dwell_i,
  output logic                dec_gain_o,
  output logic                inc_gain_o
);

  localparam int HOLD_W = (HOLD_MIN > 1) ? $clog2(HOLD_MIN) : 1;

  logic               live_q;
  logic [MAG_W-1:0]   mag_q;
  logic [DWELL_W-1:0] run_q;
  logic [DWELL_W-1:0] dwell_eff;
  logic               over, below;
  logic [1:0]         raw, flag, flag_q;
  logic [HOLD_W-1:0]  hold_q [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      mag_q  <= '0;
    end else begin
      live_q <= 1'b1;
      mag_q  <= mag_i;
    end
  end

  assign dwell_eff = (dwell_i == '0) ? DWELL_W'(1) : dwell_i;
  assign over      = live_q && (mag_q[MAG_W-1 -: COARSE_W] > coarse_hi_i);
  assign below     = live_q && (mag_q < fine_lo_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (!below)     run_q <= '0;
    else if (run_q != '1) run_q <= run_q + DWELL_W'(1);
  end

  assign raw[0] = over;
  assign raw[1] = below && (run_q >= (dwell_eff - DWELL_W'(1)));

  for (genvar g = 0; g < 2; g++) begin : g_stretch
    assign flag[g] = raw[g] | (hold_q[g] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
        hold_q[g] <= '0;
      end else begin
        flag_q[g] <= flag[g];
        if (flag[g] && !flag_q[g])  hold_q[g] <= HOLD_W'(HOLD_MIN - 1);
        else if (hold_q[g] != '0)   hold_q[g] <= hold_q[g] - HOLD_W'(1);
      end
    end
  end

  assign dec_gain_o = flag[0];
  assign inc_gain_o = flag[1];

endmodule

// File: rtl/gain_flag_gen_chk.sv
module gain_flag_gen_chk #(
  parameter int MAG_W    = 13,
  parameter int COARSE_W = 3,
  parameter int DWELL_W  = 16,
  parameter int HOLD_MIN = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [MAG_W-1:0]    mag_i,
  input logic [COARSE_W-1:0] coarse_hi_i,
  input logic [MAG_W-1:0]    fine_lo_i,
  input logic [DWELL_W-1:0]  dwell_i,
  input logic                dec_gain_o,
  input logic                inc_gain_o
);

  logic             armed;
  logic [DWELL_W:0] low_run;
  logic [DWELL_W:0] need;

  assign need = (dwell_i == '0) ? (DWELL_W+1)'(1) : {1'b0, dwell_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      low_run <= '0;
    end else begin
      armed <= 1'b1;
      if (mag_i >= fine_lo_i)  low_run <= '0;
      else if (low_run != '1)  low_run <= low_run + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!dec_gain_o && !inc_gain_o); // R1
    end
  end

  AST_DEC_ON_OVER: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(mag_i[MAG_W-1 -: COARSE_W]) > $past(coarse_hi_i)) |-> dec_gain_o); // R2

  AST_DEC_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(dec_gain_o) |-> ($past(mag_i[MAG_W-1 -: COARSE_W]) > $past(coarse_hi_i))); // R3

  AST_INC_DWELL_MET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(inc_gain_o) |-> (low_run >= need)); // R4

  AST_INC_DROP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(inc_gain_o) && $past(inc_gain_o, 2) && ($past(mag_i) >= $past(fine_lo_i))) |-> !inc_gain_o); // R6

  AST_DEC_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_gain_o) |=> dec_gain_o); // R8

  AST_INC_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inc_gain_o) |=> inc_gain_o); // R8

endmodule

bind gain_flag_gen gain_flag_gen_chk #(
  .MAG_W(MAG_W), .COARSE_W(COARSE_W), .DWELL_W(DWELL_W), .HOLD_MIN(HOLD_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mag_i(mag_i), .coarse_hi_i(coarse_hi_i),
  .fine_lo_i(fine_lo_i), .dwell_i(dwell_i),
  .dec_gain_o(dec_gain_o), .inc_gain_o(inc_gain_o)
);

// File: tb/gain_flag_gen_tb.sv
module gain_flag_gen_tb;
  localparam int MAG_W = 13, COARSE_W = 3, DWELL_W = 16;
  localparam int SHIFT = MAG_W - COARSE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MAG_W-1:0]    mag = '0;
  logic [COARSE_W-1:0] coarse = 3'd5;
  logic [MAG_W-1:0]    fine = 13'd1000;
  logic [DWELL_W-1:0]  dwell = 16'd5;
  logic dec_o, inc_o;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  int run = 0, dage = 0, iage = 0, dw;
  bit de = 0, ie = 0, nd, ni, ov, bl;

  always #5 clk = ~clk;

  gain_flag_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mag_i(mag), .coarse_hi_i(coarse),
    .fine_lo_i(fine), .dwell_i(dwell), .dec_gain_o(dec_o), .inc_gain_o(inc_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      run = 0; de = 0; ie = 0; dage = 0; iage = 0;
    end else begin
      ov  = (int'(mag) >> SHIFT) > int'(coarse);
      bl  = int'(mag) < int'(fine);
      run = bl ? run + 1 : 0;
      dw  = (dwell == 0) ? 1 : int'(dwell);
      nd  = ov || (de && dage == 1);
      dage = nd ? dage + 1 : 0;
      de  = nd;
      ni  = (bl && run >= dw) || (ie && iage == 1);
      iage = ni ? iage + 1 : 0;
      ie  = ni;
    end
    #2;
    if (!done) begin
      checks += 2;
      if (dec_o !== de) begin
        errors++;
        $display("FAIL %s cycle %0d dec_gain_o actual %0b expected %0b", tag, cyc, dec_o, de);
      end
      if (inc_o !== ie) begin
        errors++;
        $display("FAIL %s cycle %0d inc_gain_o actual %0b expected %0b", tag, cyc, inc_o, ie);
      end
    end
  end

  task automatic drive(input int m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mag = MAG_W'(m);
    end
  endtask

  initial begin
    tag = "R1";
    drive(7000, 4);
    @(negedge clk); mag = 13'd2000; rst_n = 1'b1;
    drive(2000, 3);

    tag = "R2";                 // top bits 5 vs ceiling 5: no; 6 vs 5: yes
    drive(6143, 3); drive(6144, 4); drive(2000, 3); drive(8191, 2); drive(2000, 3);

    tag = "R3";                 // level following after the stretch
    drive(7000, 3); drive(2000, 1); drive(7000, 4); drive(3000, 3);

    tag = "R8";                 // single-sample spikes on both flags
    drive(7000, 1); drive(2000, 4);
    dwell = 16'd1;
    drive(500, 1); drive(2000, 4);

    tag = "R4";
    dwell = 16'd5;
    drive(500, 4); drive(2000, 3); drive(500, 5); drive(2000, 4);

    tag = "R5";                 // a sample equal to the floor restarts the run
    drive(500, 3); drive(1000, 1); drive(500, 4); drive(1000, 1); drive(500, 6); drive(2000, 4);

    tag = "R6";
    drive(500, 12); drive(1000, 1); drive(500, 2); drive(2000, 4);

    tag = "R7";
    dwell = 16'd0;
    drive(500, 1); drive(2000, 4); drive(500, 3); drive(2000, 4);

    tag = "R1";
    @(negedge clk); rst_n = 1'b0; mag = 13'd500;
    drive(7000, 3);
    @(negedge clk); rst_n = 1'b1;
    drive(2000, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule